// File: doc/BRIEF.md
# Stereo Transmit Sample Buffer

This block holds 24-bit audio samples on their way to a serial digital-audio transmitter. Two independent first-in first-out stores, one per channel, are filled by software through a left write port and a right write port. The transmitter's frame-rate request drains them one left/right pair at a time. The sample pair it takes appears on two registered output buses.

A two-bit operating mode picks what a request does. It can emit digital silence, drain the stores normally, or trim both stores down to a single waiting sample. A two-bit threshold selector defines when the level-sensitive empty flag is raised. An optional alignment check compares the two occupancies whenever a request arrives. On a mismatch it flushes both stores and raises a sticky resync flag. Popping from an empty store, or pushing into a full one, raises a sticky under/overrun flag. A synchronous soft reset clears both stores and both flags.

A four-state machine sequences the block. ZERO emits silence, with pushes accepted and no pops. DRAIN pops a pair on each request. TRIM holds both stores at one sample. FLUSH empties both stores for one cycle. Every clock the machine takes its next state from the sampled mode: code 01 leads to DRAIN, code 10 to TRIM, and codes 00 and 11 to ZERO. There are two exceptions. A request in DRAIN that finds the occupancies unequal with alignment checking on moves the machine to FLUSH. Soft reset moves it to ZERO.

Top module: `sttx_sample_buf`

## Requirements
- R1: After the asynchronous reset is released, both outputs are zero, both levels are 0, both status flags are low, and the empty flag is high.
- R2: A write strobe on a channel stores its 24-bit sample in that channel's store and raises that level by one. The stores hold 16 samples each, and a level never exceeds 16.
- R3: With DRAIN active, a request pops the oldest left sample and the oldest right sample. They appear on the outputs after the clock edge that samples the request. A write and a pop in the same cycle leave the level unchanged.
- R4: With ZERO active (mode code 00 or 11), a request drives both outputs to zero and both levels are left unchanged. Writes are still accepted.
- R5: With TRIM active (mode code 10), each store keeps only its oldest sample, and its level becomes 1 after the first TRIM clock. A store that was empty is given one zero sample. Writes are ignored, and requests output zero.
- R6: The empty flag is high exactly when both levels are at most 4 x the threshold code (00, 01, 10 and 11 give 0, 4, 8 and 12).
- R7: With alignment checking on, a request in DRAIN that sees unequal levels outputs zeros and sets the sticky resync flag. Both levels are 0 one clock later, and writes during that FLUSH clock are ignored.
- R8: A request in DRAIN with either store empty, and with no alignment mismatch, outputs zeros, pops nothing, and sets the sticky under/overrun flag.
- R9: A write to a store that held 16 samples before the edge is dropped and sets the under/overrun flag. This applies even if a pop happens in the same cycle.
- R10: Soft reset clears both stores, both outputs and both status flags at the next edge, and places the machine in ZERO.
- R11: A new mode takes effect on the clock after the edge that samples it, through the state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous clear of stores and flags |
| tx_mode | input | 2 | 00/11 silence, 01 drain, 10 trim to one |
| empty_sel | input | 2 | Empty threshold code, threshold = 4 x code |
| autosync_en | input | 1 | Enables the left/right occupancy check |
| wr_left | input | 1 | Left write strobe |
| wr_left_data | input | 24 | Left sample |
| wr_right | input | 1 | Right write strobe |
| wr_right_data | input | 24 | Right sample |
| frame_req | input | 1 | Frame-rate sample pair request |
| out_left | output | 24 | Left sample handed to the encoder |
| out_right | output | 24 | Right sample handed to the encoder |
| left_level | output | 5 | Left occupancy, 0 to 16 |
| right_level | output | 5 | Right occupancy, 0 to 16 |
| empty_flag | output | 1 | Both occupancies at or below threshold |
| resync_flag | output | 1 | Sticky alignment-loss status |
| unov_flag | output | 1 | Sticky underrun/overrun status |

## Verification
The bench fills a store to 16 and writes once more while popping in the same cycle. A design that tested fullness after the pop would then accept a seventeenth sample. It also trims an empty store. A design that raised the level without writing a zero sample would then hand out stale data on the next pop. Unequal levels are set up before a request with alignment checking on. A design that flushed on the request edge itself, instead of one clock later, would either drop a write too early or keep one too long. Long random runs switch modes and the alignment check while writes and requests land on the same edges, so a state register that got an R11 transition wrong shows up as a pop in the wrong cycle.

// File: rtl/sttx_pkg.sv
package sttx_pkg;

    // Operating mode codes on tx_mode
    localparam logic [1:0] MODE_ZERO  = 2'b00;
    localparam logic [1:0] MODE_DRAIN = 2'b01;
    localparam logic [1:0] MODE_TRIM  = 2'b10;

    typedef enum logic [1:0] {
        ST_ZERO  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_TRIM  = 2'd2,
        ST_FLUSH = 2'd3
    } sttx_state_e;

endpackage

// File: rtl/sttx_chan_fifo.sv
module sttx_chan_fifo #(
    parameter int DW    = 24,
    parameter int DEPTH = 16,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          trim,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic [LW-1:0] level
);
    localparam int AW = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] rd_ptr;
    logic [AW-1:0] wr_ptr;

    assign dout = mem[rd_ptr];

    // Pointers and occupancy
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            level  <= '0;
        end else if (clr) begin
            wr_ptr <= rd_ptr;
            level  <= '0;
        end else if (trim) begin
            wr_ptr <= rd_ptr + AW'(1);
            level  <= LW'(1);
        end else begin
            if (push) wr_ptr <= wr_ptr + AW'(1);
            if (pop)  rd_ptr <= rd_ptr + AW'(1);
            level <= level + LW'(push) - LW'(pop);
        end
    end

    // Sample storage, no reset
    always_ff @(posedge clk) begin
        if (trim && level == '0) begin
            mem[rd_ptr] <= '0;
        end else if (!clr && !trim && push) begin
            mem[wr_ptr] <= din;
        end
    end

endmodule

// File: rtl/sttx_fsm.sv
module sttx_fsm
    import sttx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst,
    input  logic [1:0]  tx_mode,
    input  logic        resync_hit,
    output sttx_state_e state,
    output logic        push_en,
    output logic        drain_en,
    output logic        trim_en,
    output logic        clr_en
);
    sttx_state_e state_nx;

    function automatic sttx_state_e mode_target(input logic [1:0] m);
        unique case (m)
            MODE_DRAIN: return ST_DRAIN;
            MODE_TRIM:  return ST_TRIM;
            default:    return ST_ZERO;
        endcase
    endfunction

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_ZERO;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = mode_target(tx_mode);
        if (soft_rst) begin
            state_nx = ST_ZERO;
        end else begin
            unique case (state)
                ST_DRAIN: if (resync_hit) state_nx = ST_FLUSH;
                ST_ZERO, ST_TRIM, ST_FLUSH: state_nx = mode_target(tx_mode);
                default:  state_nx = ST_ZERO;
            endcase
        end
    end

    // Per-state controls
    always_comb begin
        push_en  = 1'b0;
        drain_en = 1'b0;
        trim_en  = 1'b0;
        clr_en   = soft_rst;
        unique case (state)
            ST_ZERO:  push_en = !soft_rst;
            ST_DRAIN: begin
                push_en  = !soft_rst;
                drain_en = !soft_rst;
            end
            ST_TRIM:  trim_en = !soft_rst;
            ST_FLUSH: clr_en  = 1'b1;
            default:  clr_en  = 1'b1;
        endcase
    end

endmodule

// File: rtl/sttx_sample_buf.sv
module sttx_sample_buf
    import sttx_pkg::*;
#(
    parameter  int DW    = 24,
    parameter  int DEPTH = 16,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic [1:0]    tx_mode,
    input  logic [1:0]    empty_sel,
    input  logic          autosync_en,
    input  logic          wr_left,
    input  logic [DW-1:0] wr_left_data,
    input  logic          wr_right,
    input  logic [DW-1:0] wr_right_data,
    input  logic          frame_req,
    output logic [DW-1:0] out_left,
    output logic [DW-1:0] out_right,
    output logic [LW-1:0] left_level,
    output logic [LW-1:0] right_level,
    output logic          empty_flag,
    output logic          resync_flag,
    output logic          unov_flag
);
    localparam int NCH = 2;

    sttx_state_e   state;
    logic          push_en, drain_en, trim_en, clr_en;
    logic          mismatch, pair_ready, resync_hit, underrun, pop_pair;
    logic [NCH-1:0] ch_wr, ch_full, ch_push, ch_ovr;
    logic [DW-1:0] ch_din  [NCH];
    logic [DW-1:0] ch_dout [NCH];
    logic [LW-1:0] ch_lvl  [NCH];
    logic [LW-1:0] thresh;

    assign ch_wr     = {wr_right, wr_left};
    assign ch_din[0] = wr_left_data;
    assign ch_din[1] = wr_right_data;

    assign left_level  = ch_lvl[0];
    assign right_level = ch_lvl[1];

    assign mismatch   = autosync_en && (ch_lvl[0] != ch_lvl[1]);
    assign pair_ready = (ch_lvl[0] != '0) && (ch_lvl[1] != '0);
    assign resync_hit = drain_en && frame_req && mismatch;
    assign underrun   = drain_en && frame_req && !mismatch && !pair_ready;
    assign pop_pair   = drain_en && frame_req && !mismatch && pair_ready;

    sttx_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .tx_mode    (tx_mode),
        .resync_hit (resync_hit),
        .state      (state),
        .push_en    (push_en),
        .drain_en   (drain_en),
        .trim_en    (trim_en),
        .clr_en     (clr_en)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        assign ch_full[g] = (ch_lvl[g] == LW'(DEPTH));
        assign ch_push[g] = ch_wr[g] && push_en && !ch_full[g];
        assign ch_ovr[g]  = ch_wr[g] && push_en &&  ch_full[g];

        sttx_chan_fifo #(
            .DW    (DW),
            .DEPTH (DEPTH),
            .LW    (LW)
        ) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_en),
            .trim  (trim_en),
            .push  (ch_push[g]),
            .din   (ch_din[g]),
            .pop   (pop_pair),
            .dout  (ch_dout[g]),
            .level (ch_lvl[g])
        );
    end

    // Threshold is four samples per code step
    assign thresh     = LW'({empty_sel, 2'b00});
    assign empty_flag = (ch_lvl[0] <= thresh) && (ch_lvl[1] <= thresh);

    // Output pair register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_left  <= '0;
            out_right <= '0;
        end else if (soft_rst) begin
            out_left  <= '0;
            out_right <= '0;
        end else if (frame_req) begin
            out_left  <= pop_pair ? ch_dout[0] : '0;
            out_right <= pop_pair ? ch_dout[1] : '0;
        end
    end

    // Sticky status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resync_flag <= 1'b0;
            unov_flag   <= 1'b0;
        end else if (soft_rst) begin
            resync_flag <= 1'b0;
            unov_flag   <= 1'b0;
        end else begin
            resync_flag <= resync_flag | resync_hit;
            unov_flag   <= unov_flag | underrun | (|ch_ovr);
        end
    end

endmodule

// File: rtl/sttx_sample_buf_chk.sv
module sttx_sample_buf_chk #(
    parameter int DW    = 24,
    parameter int DEPTH = 16,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          soft_rst,
    input logic          frame_req,
    input logic [DW-1:0] out_left,
    input logic [DW-1:0] out_right,
    input logic [LW-1:0] left_level,
    input logic [LW-1:0] right_level,
    input logic          empty_flag,
    input logic          resync_flag,
    input logic          unov_flag
);
    // R2
    lvl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (left_level <= LW'(DEPTH)) && (right_level <= LW'(DEPTH)));

    // R8
    underrun_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_req && !soft_rst && (left_level == '0 || right_level == '0))
        |=> (out_left == '0 && out_right == '0));

    // R8
    unov_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unov_flag && !soft_rst) |=> unov_flag);

    // R10
    soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (left_level == '0 && right_level == '0 && !resync_flag && !unov_flag));

    // R7
    resync_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resync_flag && !$past(resync_flag) && !soft_rst)
        |=> (left_level == '0 && right_level == '0));

    // R6
    empty_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (left_level == '0 && right_level == '0) |-> empty_flag);

endmodule

bind sttx_sample_buf sttx_sample_buf_chk #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .frame_req   (frame_req),
    .out_left    (out_left),
    .out_right   (out_right),
    .left_level  (left_level),
    .right_level (right_level),
    .empty_flag  (empty_flag),
    .resync_flag (resync_flag),
    .unov_flag   (unov_flag)
);

// File: tb/sttx_sample_buf_bench.sv
module sttx_sample_buf_bench;
    localparam int DW = 24;
    localparam int DEPTH = 16;
    localparam int LW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 1'b0;
    logic [1:0] tx_mode = 2'b00;
    logic [1:0] empty_sel = 2'b00;
    logic autosync_en = 1'b0;
    logic wr_left = 1'b0, wr_right = 1'b0, frame_req = 1'b0;
    logic [DW-1:0] wr_left_data = '0, wr_right_data = '0;
    logic [DW-1:0] out_left, out_right;
    logic [LW-1:0] left_level, right_level;
    logic empty_flag, resync_flag, unov_flag;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sttx_sample_buf u_sttx_sample_buf (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .tx_mode(tx_mode),
        .empty_sel(empty_sel), .autosync_en(autosync_en),
        .wr_left(wr_left), .wr_left_data(wr_left_data),
        .wr_right(wr_right), .wr_right_data(wr_right_data),
        .frame_req(frame_req), .out_left(out_left), .out_right(out_right),
        .left_level(left_level), .right_level(right_level),
        .empty_flag(empty_flag), .resync_flag(resync_flag), .unov_flag(unov_flag)
    );

    // Reference model
    logic [DW-1:0] ql[$];
    logic [DW-1:0] qr[$];
    logic [DW-1:0] m_l = '0, m_r = '0;
    bit m_res = 0, m_unov = 0;
    int m_st = 0; // 0 zero, 1 drain, 2 trim, 3 flush

    function automatic int target(input logic [1:0] m);
        if (m == 2'b01) return 1;
        if (m == 2'b10) return 2;
        return 0;
    endfunction

    function automatic bit exp_empty();
        int thr = int'(empty_sel) * 4;
        return (ql.size() <= thr) && (qr.size() <= thr);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_edge();
        int szl = ql.size();
        int szr = qr.size();
        int nst = target(tx_mode);
        bit pushes = 0;
        if (soft_rst) begin
            ql.delete(); qr.delete();
            m_l = '0; m_r = '0; m_res = 0; m_unov = 0; m_st = 0;
            return;
        end
        case (m_st)
            0: begin
                pushes = 1;
                if (frame_req) begin m_l = '0; m_r = '0; end
            end
            1: begin
                pushes = 1;
                if (frame_req) begin
                    if (autosync_en && szl != szr) begin
                        m_l = '0; m_r = '0; m_res = 1; nst = 3;
                    end else if (szl == 0 || szr == 0) begin
                        m_l = '0; m_r = '0; m_unov = 1;
                    end else begin
                        m_l = ql.pop_front(); m_r = qr.pop_front();
                    end
                end
            end
            2: begin
                if (szl == 0) ql.push_back('0); else while (ql.size() > 1) void'(ql.pop_back());
                if (szr == 0) qr.push_back('0); else while (qr.size() > 1) void'(qr.pop_back());
                if (frame_req) begin m_l = '0; m_r = '0; end
            end
            default: begin
                ql.delete(); qr.delete();
                if (frame_req) begin m_l = '0; m_r = '0; end
            end
        endcase
        if (pushes) begin
            if (wr_left)  begin if (szl == DEPTH) m_unov = 1; else ql.push_back(wr_left_data); end
            if (wr_right) begin if (szr == DEPTH) m_unov = 1; else qr.push_back(wr_right_data); end
        end
        m_st = nst;
    endtask

    task automatic compare(input string tag);
        chk(out_left == m_l, {tag, " out_left R3"}, out_left, m_l);
        chk(out_right == m_r, {tag, " out_right R3"}, out_right, m_r);
        chk(int'(left_level) == ql.size(), {tag, " left_level R2"}, left_level, ql.size());
        chk(int'(right_level) == qr.size(), {tag, " right_level R2"}, right_level, qr.size());
        chk(empty_flag == exp_empty(), {tag, " empty R6"}, empty_flag, exp_empty());
        chk(resync_flag == m_res, {tag, " resync R7"}, resync_flag, m_res);
        chk(unov_flag == m_unov, {tag, " unov R8/R9"}, unov_flag, m_unov);
    endtask

    task automatic step(input bit wl, input logic [DW-1:0] dl, input bit wr,
                        input logic [DW-1:0] dr, input bit rq, input string tag);
        wr_left = wl; wr_left_data = dl; wr_right = wr; wr_right_data = dr; frame_req = rq;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        wr_left = 0; wr_right = 0; frame_req = 0;
        compare(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, '0, 0, '0, 0, tag);
    endtask

    task automatic push_pairs(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1, DW'($urandom), 1, DW'($urandom), 0, tag);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        compare("R1 reset");
        chk(empty_flag == 1'b1, "R1 empty after reset", empty_flag, 1);

        // R2/R9 fill in ZERO mode then overflow
        push_pairs(DEPTH, "R2 fill");
        step(1, 24'h111111, 0, '0, 0, "R9 overflow left");
        chk(unov_flag == 1'b1, "R9 flag set", unov_flag, 1);

        // R11 mode to DRAIN takes one clock; R3 drain
        tx_mode = 2'b01;
        step(0, '0, 0, '0, 1, "R11 request in old ZERO state");
        step(0, '0, 0, '0, 1, "R3 first pop");
        // R9 push to full with simultaneous pop (level was 15 after one pop -> fill)
        step(1, 24'h0A0A0A, 1, 24'h0B0B0B, 0, "R2 refill");
        step(1, 24'h0C0C0C, 1, 24'h0D0D0D, 1, "R9 push and pop at full");
        for (int i = 0; i < 20; i++) step(0, '0, 0, '0, 1, "R3 drain");
        // R8 underrun
        soft_rst = 1; step(0, '0, 0, '0, 0, "R10 soft reset"); soft_rst = 0;
        step(0, '0, 0, '0, 1, "R8 underrun");

        // R6 thresholds
        for (int s = 0; s < 4; s++) begin
            empty_sel = 2'(s);
            push_pairs(4, "R6 threshold");
        end
        push_pairs(1, "R6 above 12");

        // R4 ZERO mode, code 11
        tx_mode = 2'b11;
        idle(1, "R11 switch");
        step(0, '0, 0, '0, 1, "R4 zero output code 11");
        tx_mode = 2'b00;
        step(1, 24'h123456, 1, 24'h654321, 1, "R4 zero output code 00");

        // R5 trim non-empty, then ignore writes
        tx_mode = 2'b10;
        step(0, '0, 0, '0, 0, "R11 to trim");
        step(1, 24'hABCDEF, 1, 24'hFEDCBA, 1, "R5 trim");
        tx_mode = 2'b01;
        step(0, '0, 0, '0, 1, "R5 trim leaves one");
        step(0, '0, 0, '0, 1, "R5 pop kept sample");
        // R5 trim an empty store
        tx_mode = 2'b10; idle(3, "R5 trim empty");
        tx_mode = 2'b01; idle(1, "R11 back");
        step(0, '0, 0, '0, 1, "R5 zero sample pop");

        // R7 resync
        autosync_en = 1;
        step(1, 24'h000777, 0, '0, 0, "R7 setup");
        step(1, 24'h000888, 1, 24'h000999, 0, "R7 setup");
        step(0, '0, 1, 24'h000AAA, 1, "R7 mismatch request");
        step(1, 24'h000BBB, 1, 24'h000CCC, 0, "R7 flush ignores writes");
        chk(resync_flag == 1'b1, "R7 flag", resync_flag, 1);
        chk(left_level == '0, "R7 flushed", left_level, 0);

        // R10 soft reset
        soft_rst = 1; step(0, '0, 0, '0, 0, "R10 soft reset"); soft_rst = 0;
        chk(resync_flag == 1'b0, "R10 flags cleared", resync_flag, 0);

        // Random mix
        for (int i = 0; i < 6000; i++) begin
            int r = int'($urandom_range(0, 99));
            if (r < 3) tx_mode = 2'($urandom);
            else if (r < 20) tx_mode = 2'b01;
            if (($urandom & 32'hFF) == 0) autosync_en = ~autosync_en;
            if (($urandom & 32'h3F) == 0) empty_sel = 2'($urandom);
            soft_rst = (($urandom & 32'h1FF) == 0);
            step(($urandom % 3) != 0, DW'($urandom), ($urandom % 3) != 0, DW'($urandom),
                 ($urandom % 2) == 0, "R3 random");
            soft_rst = 0;
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule